// File: doc/BRIEF.md
# Stepper Microstepping Indexer

This block turns a step-and-direction command stream into per-phase current targets for a two-phase bipolar stepper. It holds an electrical-angle position on a 64-point grid, where each point is 5.625°. Each rising edge of the step input moves the position forward or backward by a stride that depends on the selected step mode. For each phase it reports a magnitude code and a sign. Phase A follows the sine of the angle and phase B follows the cosine. It also reports whether each phase's magnitude grew or shrank on the last step, so the downstream current regulator can pick its decay behaviour.

The step input is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. A home request returns the position to the 45° diagonal. The enclosing logic asserts it on a logic-level reset or when leaving sleep. Bridge-disable and low-supply conditions are handled outside this block, so the indexer keeps counting steps through them. The outputs change only on a step or a home event. A mode change made between steps is applied on the next step, which first moves to the nearest position that is valid for the new mode.

Top module: `stepper_indexer`

## Requirements
- R1: When `rst_n` is low at a clock edge, or `home_req` is high at a clock edge, the block enters the home state after that edge. In the home state `angle_o` is 8 (45°), both magnitude codes are 9, both signs are 0 and all four rise and fall flags are 0.
- R2: A step is taken once per rising edge of `step_in`. `angle_o` changes on the third rising clock edge after the first edge that samples `step_in` high. Holding `step_in` high gives no further steps, and with no step the outputs hold their values.
- R3: In mode 5 (1/16 step) each step adds 1 to `angle_o` when `dir_in` is 1 and subtracts 1 when it is 0, wrapping modulo 64.
- R4: Modes 4 (1/8), 3 (1/4) and 2 (half step) use strides of 2, 4 and 8, on positions that are multiples of the stride.
- R5: Mode 0 (full step) uses only positions 8, 24, 40 and 56 (45°, 135°, 225°, 315°), with a stride of 16.
- R6: After a mode change, the next step moves to the nearest position that is valid for the new mode and lies strictly beyond the current one in the direction set by `dir_in`.
- R7: A magnitude code lies in the range 1 to 16. The codes 1 to 16 stand for 0, 10, 20, 29, 38, 47, 56, 63, 71, 77, 83, 88, 92, 96, 98 and 100 percent. Phase A uses the sine of `angle_o`×5.625° rounded to the nearest percent, and phase B uses the cosine.
- R8: `a_neg_o` is 1 exactly when `angle_o` is 33 to 63. `b_neg_o` is 1 exactly when `angle_o` is 17 to 47. A zero magnitude reports sign 0.
- R9: Mode 1 (square-current half step) steps on multiples of 8. On the diagonal positions 8, 24, 40 and 56 both phases get code 16. On the axis positions one phase gets code 16 and the other gets code 1.
- R10: On each step, a phase's rise flag is set if its new code is greater than the previous code, and its fall flag is set if the new code is smaller. Both flags are cleared if the code is unchanged.
- R11: Mode codes 6 and 7 are reserved. A step taken while a reserved code is selected changes no output.
- R12: `home_req` takes priority over a step detected in the same cycle, and that step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| home_req | input | 1 | Synchronous request to return to the home position |
| step_in | input | 1 | Asynchronous step command; rising edge advances |
| dir_in | input | 1 | 1 = increasing angle, 0 = decreasing |
| mode_sel | input | 3 | Step mode: 0 full, 1 square half, 2 half, 3 quarter, 4 eighth, 5 sixteenth, 6-7 reserved |
| angle_o | output | 6 | Electrical-angle index, 5.625° per count |
| a_mag_o | output | 5 | Phase A magnitude code (1..16) |
| a_neg_o | output | 1 | Phase A current negative |
| a_rise_o | output | 1 | Phase A magnitude grew on last step |
| a_fall_o | output | 1 | Phase A magnitude shrank on last step |
| b_mag_o | output | 5 | Phase B magnitude code (1..16) |
| b_neg_o | output | 1 | Phase B current negative |
| b_rise_o | output | 1 | Phase B magnitude grew on last step |
| b_fall_o | output | 1 | Phase B magnitude shrank on last step |

## Verification
The assertions check every cycle for the following local properties:
- the position holds when there is no step;
- each detected edge lasts a single cycle;
- a 1/16 step moves the position by exactly one count;
- full-step landings fall on the diagonals;
- reserved modes hold the position;
- magnitude codes stay in range;
- a home request lands on 45°.

Some behaviours can only be shown by the bench's scenarios against its independent reference model:
- the sine and cosine magnitudes themselves;
- rounding to the nearest valid position after a mode change;
- wrap-around in both directions;
- the square-current diagonals;
- the three-edge latency from the step input.

// File: rtl/stepidx_pkg.sv
// Shared constants for the stepper indexer: mode codes and grid geometry.
// Assumes a grid of 2**IDX_W positions per electrical cycle.
package stepidx_pkg;
    localparam int IDX_W = 6;

    localparam logic [2:0] MODE_FULL      = 3'd0;
    localparam logic [2:0] MODE_SQHALF    = 3'd1;
    localparam logic [2:0] MODE_HALF      = 3'd2;
    localparam logic [2:0] MODE_QUARTER   = 3'd3;
    localparam logic [2:0] MODE_EIGHTH    = 3'd4;
    localparam logic [2:0] MODE_SIXTEENTH = 3'd5;

    // True for mode codes that carry no stepping behaviour.
    function automatic logic is_reserved(input logic [2:0] m);
        return (m > MODE_SIXTEENTH);
    endfunction
endpackage

// File: rtl/stepidx_sync.sv
// Synchronizer and rising-edge detector for the asynchronous step input.
// Assumes step pulses are wider than one clock period. Produces a
// one-cycle pulse, SYNC_STAGES+1 edges after the input is first sampled high.
module stepidx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_async,
    output logic step_rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Shift the raw input through the synchronizer chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= step_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], step_async};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    assign step_rise = chain_q[SYNC_STAGES-1] & ~last_q;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_rise |=> !step_rise);
endmodule

// File: rtl/stepidx_advance.sv
// Next-position computation for one step in the selected mode.
// Each mode defines a grid of valid positions (stride, offset). The result is
// the nearest grid point strictly beyond the current position in the step
// direction, so a misaligned position realigns in the direction of motion.
module stepidx_advance #(
    parameter int POS_W = stepidx_pkg::IDX_W
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [2:0]       mode_i,
    input  logic             dir_i,
    output logic [POS_W-1:0] pos_o,
    output logic             valid_o
);
    import stepidx_pkg::*;

    localparam int QTR = 1 << (POS_W - 2);

    logic [POS_W-1:0] stride, offset, mask, rel, fwd, bwd;

    // Pick the grid stride and offset for the selected mode.
    always_comb begin
        valid_o = 1'b1;
        offset  = '0;
        unique case (mode_i)
            MODE_SIXTEENTH: stride = POS_W'(QTR / 16);
            MODE_EIGHTH:    stride = POS_W'(QTR / 8);
            MODE_QUARTER:   stride = POS_W'(QTR / 4);
            MODE_HALF,
            MODE_SQHALF:    stride = POS_W'(QTR / 2);
            MODE_FULL: begin
                stride = POS_W'(QTR);
                offset = POS_W'(QTR / 2);
            end
            default: begin
                stride  = POS_W'(1);
                valid_o = 1'b0;
            end
        endcase
    end

    // Round to the grid in the direction of motion, then take one stride.
    always_comb begin
        mask  = ~(stride - POS_W'(1));
        rel   = pos_i - offset;
        fwd   = (rel & mask) + stride + offset;
        bwd   = ((rel + stride - POS_W'(1)) & mask) - stride + offset;
        pos_o = dir_i ? fwd : bwd;
    end
endmodule

// File: rtl/stepidx_phase.sv
// Magnitude and sign lookup for one phase at a given grid position.
// PH_OFS shifts the angle (0 gives the sine phase, a quarter cycle gives the cosine).
// The quarter-wave index is folded from the angle. The code is index+1, held at
// full scale over the last two points. Square mode forces diagonals to full scale.
module stepidx_phase #(
    parameter int POS_W  = stepidx_pkg::IDX_W,
    parameter int MAG_W  = 5,
    parameter int PH_OFS = 0
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic             square_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);
    localparam int QTR  = 1 << (POS_W - 2);
    localparam int HALF = 2 * QTR;

    logic [POS_W-1:0] ang;
    logic [POS_W-2:0] in_half;
    logic [POS_W-1:0] fold;
    logic             diag;

    // Fold the shifted angle into a quarter-wave index.
    always_comb begin
        ang     = pos_i + POS_W'(PH_OFS);
        in_half = ang[POS_W-2:0];
        if ({1'b0, in_half} <= POS_W'(QTR)) fold = {1'b0, in_half};
        else                                fold = POS_W'(HALF) - {1'b0, in_half};
        diag    = (ang[POS_W-3:0] == (POS_W-2)'(QTR / 2));
    end

    // Map the folded index to a code and decide the sign.
    always_comb begin
        if (square_i && diag)                 mag_o = MAG_W'(QTR);
        else if (fold >= POS_W'(QTR - 1))     mag_o = MAG_W'(QTR);
        else                                  mag_o = MAG_W'(fold) + MAG_W'(1);
        neg_o = ang[POS_W-1] && (in_half != '0);
    end
endmodule

// File: rtl/stepper_indexer.sv
// Step/direction microstepping indexer for a two-phase bipolar stepper.
// Keeps an electrical-angle index, advances it on synchronized step edges by
// the stride of the selected mode, and registers per-phase magnitude, sign
// and rise/fall flags. Assumes home_req is synchronous to clk.
module stepper_indexer #(
    parameter int POS_W       = stepidx_pkg::IDX_W,
    parameter int SYNC_STAGES = 2,
    parameter int MAG_W       = $clog2((1 << (POS_W - 2)) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             home_req,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [2:0]       mode_sel,
    output logic [POS_W-1:0] angle_o,
    output logic [MAG_W-1:0] a_mag_o,
    output logic             a_neg_o,
    output logic             a_rise_o,
    output logic             a_fall_o,
    output logic [MAG_W-1:0] b_mag_o,
    output logic             b_neg_o,
    output logic             b_rise_o,
    output logic             b_fall_o
);
    import stepidx_pkg::*;

    localparam int QTR = 1 << (POS_W - 2);
    localparam logic [POS_W-1:0] HOME_POS  = POS_W'(QTR / 2);
    localparam logic [MAG_W-1:0] HOME_CODE = MAG_W'(QTR / 2 + 1);
    localparam int NPH = 2;

    logic             step_rise;
    logic [POS_W-1:0] pos_q, pos_nxt;
    logic             adv_ok, take_step, square_mode;
    logic [MAG_W-1:0] mag_nxt [NPH];
    logic             neg_nxt [NPH];
    logic [MAG_W-1:0] mag_q   [NPH];
    logic             neg_q   [NPH];
    logic             rise_q  [NPH];
    logic             fall_q  [NPH];

    stepidx_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_async (step_in),
        .step_rise  (step_rise)
    );

    stepidx_advance #(.POS_W(POS_W)) i_adv (
        .pos_i   (pos_q),
        .mode_i  (mode_sel),
        .dir_i   (dir_in),
        .pos_o   (pos_nxt),
        .valid_o (adv_ok)
    );

    assign square_mode = (mode_sel == MODE_SQHALF);
    assign take_step   = step_rise && adv_ok;

    // Hold the electrical-angle index; home wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n || home_req) pos_q <= HOME_POS;
        else if (take_step)     pos_q <= pos_nxt;
    end

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_phase
            stepidx_phase #(
                .POS_W  (POS_W),
                .MAG_W  (MAG_W),
                .PH_OFS (p * QTR)
            ) i_phase (
                .pos_i    (pos_nxt),
                .square_i (square_mode),
                .mag_o    (mag_nxt[p]),
                .neg_o    (neg_nxt[p])
            );

            // Register this phase's target and its trend at each step.
            always_ff @(posedge clk) begin
                if (!rst_n || home_req) begin
                    mag_q[p]  <= HOME_CODE;
                    neg_q[p]  <= 1'b0;
                    rise_q[p] <= 1'b0;
                    fall_q[p] <= 1'b0;
                end else if (take_step) begin
                    mag_q[p]  <= mag_nxt[p];
                    neg_q[p]  <= neg_nxt[p];
                    rise_q[p] <= (mag_nxt[p] > mag_q[p]);
                    fall_q[p] <= (mag_nxt[p] < mag_q[p]);
                end
            end
        end
    endgenerate

    assign angle_o  = pos_q;
    assign a_mag_o  = mag_q[0];
    assign a_neg_o  = neg_q[0];
    assign a_rise_o = rise_q[0];
    assign a_fall_o = fall_q[0];
    assign b_mag_o  = mag_q[1];
    assign b_neg_o  = neg_q[1];
    assign b_rise_o = rise_q[1];
    assign b_fall_o = fall_q[1];

    // R1
    home_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        home_req |=> (angle_o == HOME_POS && a_mag_o == HOME_CODE && b_mag_o == HOME_CODE));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_rise && !home_req) |=> $stable(angle_o));
    // R3
    fine_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !home_req && mode_sel == MODE_SIXTEENTH && dir_in)
        |=> angle_o == POS_W'($past(angle_o) + POS_W'(1)));
    // R5
    full_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !home_req && mode_sel == MODE_FULL)
        |=> angle_o[POS_W-3:0] == (POS_W-2)'(QTR / 2));
    // R7
    mag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_mag_o >= MAG_W'(1) && a_mag_o <= MAG_W'(QTR) && b_mag_o >= MAG_W'(1) && b_mag_o <= MAG_W'(QTR));
    // R10
    rise_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rise_o |-> a_mag_o > MAG_W'(1));
    // R11
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !home_req && is_reserved(mode_sel)) |=> $stable(angle_o) && $stable(a_mag_o));
endmodule

// File: tb/test_stepper_indexer.sv
module test_stepper_indexer;
    logic       clk = 1'b0;
    logic       rst_n, home_req, step_in, dir_in;
    logic [2:0] mode_sel;
    logic [5:0] angle_o;
    logic [4:0] a_mag_o, b_mag_o;
    logic       a_neg_o, a_rise_o, a_fall_o, b_neg_o, b_rise_o, b_fall_o;

    always #10 clk = ~clk;

    stepper_indexer i_stepper_indexer (
        .clk(clk), .rst_n(rst_n), .home_req(home_req), .step_in(step_in),
        .dir_in(dir_in), .mode_sel(mode_sel), .angle_o(angle_o),
        .a_mag_o(a_mag_o), .a_neg_o(a_neg_o), .a_rise_o(a_rise_o), .a_fall_o(a_fall_o),
        .b_mag_o(b_mag_o), .b_neg_o(b_neg_o), .b_rise_o(b_rise_o), .b_fall_o(b_fall_o)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    int pct_tbl [16] = '{0, 10, 20, 29, 38, 47, 56, 63, 71, 77, 83, 88, 92, 96, 98, 100};

    // Reference model state
    int m_pos, m_am, m_bm;
    bit m_an, m_bn, m_ar, m_af, m_br, m_bf;
    int hist[$];

    function automatic int code_of(int k);
        int m = k % 32;
        real r;
        int p;
        if (m > 16) m = 32 - m;
        r = $sin(m * 5.625 * 3.14159265358979 / 180.0) * 100.0;
        p = $rtoi(r + 0.5);
        for (int i = 0; i < 16; i++) if (pct_tbl[i] == p) return i + 1;
        return -1;
    endfunction

    function automatic bit on_grid(int k, int md);
        case (md)
            0: return (k % 16) == 8;
            1, 2: return (k % 8) == 0;
            3: return (k % 4) == 0;
            4: return (k % 2) == 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_home();
        m_pos = 8; m_am = 9; m_bm = 9;
        m_an = 0; m_bn = 0; m_ar = 0; m_af = 0; m_br = 0; m_bf = 0;
    endtask

    task automatic model_step(int md, bit d);
        int np = m_pos;
        int na, nb;
        for (int i = 1; i <= 64; i++) begin
            int c = d ? (m_pos + i) % 64 : (m_pos - i + 64) % 64;
            if (on_grid(c, md)) begin np = c; break; end
        end
        na = code_of(np);
        nb = code_of((np + 16) % 64);
        if (md == 1 && (np % 16) == 8) begin na = 16; nb = 16; end
        m_ar = na > m_am; m_af = na < m_am;
        m_br = nb > m_bm; m_bf = nb < m_bm;
        m_am = na; m_bm = nb;
        m_an = np > 32;
        m_bn = (np > 16) && (np < 48);
        m_pos = np;
    endtask

    // Reference model advanced at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0, 0};
            model_home();
        end else begin
            bit evt;
            hist.push_front(int'(step_in));
            while (hist.size() > 4) void'(hist.pop_back());
            evt = (hist[2] == 1) && (hist[3] == 0);
            if (home_req) model_home();
            else if (evt && mode_sel <= 3'd5) model_step(int'(mode_sel), dir_in);
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check_eq("R3 angle vs model", int'(angle_o), m_pos);
            check_eq("R7 a_mag vs model", int'(a_mag_o), m_am);
            check_eq("R7 b_mag vs model", int'(b_mag_o), m_bm);
            check_eq("R8 a_neg vs model", int'(a_neg_o), int'(m_an));
            check_eq("R8 b_neg vs model", int'(b_neg_o), int'(m_bn));
            check_eq("R10 a_rise vs model", int'(a_rise_o), int'(m_ar));
            check_eq("R10 a_fall vs model", int'(a_fall_o), int'(m_af));
            check_eq("R10 b_rise vs model", int'(b_rise_o), int'(m_br));
            check_eq("R10 b_fall vs model", int'(b_fall_o), int'(m_bf));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic pulse_step();
        @(negedge clk); step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; home_req = 0; step_in = 0; dir_in = 1; mode_sel = 3'd5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 angle", int'(angle_o), 8);
        check_eq("R1 a_mag", int'(a_mag_o), 9);
        check_eq("R1 b_mag", int'(b_mag_o), 9);
        check_eq("R1 signs", int'({a_neg_o, b_neg_o}), 0);
        check_eq("R1 flags", int'({a_rise_o, a_fall_o, b_rise_o, b_fall_o}), 0);

        // R2 latency and single step per edge
        step_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_eq("R2 before third edge", int'(angle_o), 8);
        @(negedge clk);
        check_eq("R2 after third edge", int'(angle_o), 9);
        repeat (4) @(negedge clk);
        check_eq("R2 held high no repeat", int'(angle_o), 9);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        // R10 trend at 45 -> 50.625 degrees
        check_eq("R10 a_rise", int'(a_rise_o), 1);
        check_eq("R10 b_fall", int'(b_fall_o), 1);
        check_eq("R7 a_mag at 9", int'(a_mag_o), 10);
        check_eq("R7 b_mag at 9", int'(b_mag_o), 8);

        // R3 backward with wrap
        dir_in = 1'b0;
        for (int i = 0; i < 10; i++) pulse_step();
        check_eq("R3 wrap backward", int'(angle_o), 63);

        // R4 strides
        dir_in = 1'b1; mode_sel = 3'd4;
        pulse_step(); pulse_step();
        check_eq("R4 eighth", int'(angle_o), 2);
        mode_sel = 3'd3;
        pulse_step(); pulse_step();
        check_eq("R4 quarter", int'(angle_o), 8);
        mode_sel = 3'd2;
        pulse_step();
        check_eq("R4 half", int'(angle_o), 16);

        // R5 full step diagonals
        mode_sel = 3'd0;
        pulse_step();
        check_eq("R5 full forward", int'(angle_o), 24);
        dir_in = 1'b0;
        pulse_step(); pulse_step();
        check_eq("R5 full backward wrap", int'(angle_o), 56);
        check_eq("R8 a_neg at 315", int'(a_neg_o), 1);

        // R6 realignment on mode change
        mode_sel = 3'd5; dir_in = 1'b1;
        pulse_step();
        mode_sel = 3'd2;
        pulse_step();
        check_eq("R6 realign forward", int'(angle_o), 0);
        mode_sel = 3'd5;
        for (int i = 0; i < 5; i++) pulse_step();
        mode_sel = 3'd3; dir_in = 1'b0;
        pulse_step();
        check_eq("R6 realign backward", int'(angle_o), 4);

        // R9 square-current half step
        mode_sel = 3'd1; dir_in = 1'b1;
        pulse_step();
        check_eq("R9 diag a_mag", int'(a_mag_o), 16);
        check_eq("R9 diag b_mag", int'(b_mag_o), 16);
        pulse_step();
        check_eq("R9 axis b_mag", int'(b_mag_o), 1);
        check_eq("R8 zero sign", int'(b_neg_o), 0);
        pulse_step();
        check_eq("R8 b_neg at 135", int'(b_neg_o), 1);

        // R11 reserved mode ignores steps
        mode_sel = 3'd6;
        pulse_step();
        check_eq("R11 reserved hold", int'(angle_o), 24);
        check_eq("R11 reserved mag", int'(a_mag_o), 16);

        // R12 home request beats a coincident step
        mode_sel = 3'd5;
        @(negedge clk); step_in = 1'b1;
        @(negedge clk); home_req = 1'b1;
        repeat (4) @(negedge clk);
        home_req = 1'b0; step_in = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R12 home wins", int'(angle_o), 8);
        check_eq("R1 home mag", int'(a_mag_o), 9);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule